// File: doc/BRIEF.md
# Per-Core Interprocessor Interrupt Register File

This block holds the interprocessor-interrupt state for a single core: a 32-bit pending word, a 32-bit enable word and a 32-byte mailbox. The local core reaches them through a register port that carries an address, a size of 1, 2, 4 or 8 bytes and write data. It gets back a registered response with read data and an error flag one cycle later. The send logic of other cores posts an action number on a separate set port. The block raises its core's interrupt line while any pending bit is set.

Software clears pending bits by writing a mask to the clear register, and only the bits set in the mask are removed. The enable word is plain storage and does not gate the line. Mailbox accesses gather or scatter bytes in little-endian order and are checked against the end of the mailbox. An access whose offset is not a multiple of its size sets a sticky flag, and the access still takes place.

Top module: `ipi_core_regs`

## Requirements
- R1: Only bits [8:0] of `acc_addr` select a register; higher address bits have no effect on which register is reached.
- R2: A `set_valid` pulse with `set_num` = n (0 to 31) ORs bit n into the pending word. From the next cycle `irq` is 1, and it stays 1 if it was already 1.
- R3: A write to the clear register at offset 0x00 replaces the pending word with pending AND NOT `acc_wdata[31:0]`. `irq` drops in the following cycle only when the result is zero.
- R4: A write to the pending word at offset 0x10 or to the set register at offset 0x08 returns `rsp_err` = 1 and leaves the pending word unchanged. A read of offset 0x00 or 0x08 returns zero with no error.
- R5: The enable word at offset 0x18 reads back the last value written to its 32 bits and has no effect on `irq`.
- R6: A read inside the mailbox (offsets 0x20 to 0x3F) returns the byte at the access offset in bits [7:0], the next byte in bits [15:8] and so on. Bytes beyond the access size read as zero. `acc_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R7: A mailbox write changes only the bytes from the access offset up to offset + size - 1, taking them from the low bytes of `acc_wdata`.
- R8: A mailbox access with offset + size greater than 0x40 returns `rsp_err` = 1 and read data zero, and a write of that kind changes nothing.
- R9: An access to any offset that is neither one of the four registers nor inside the mailbox returns `rsp_err` = 1 and read data zero.
- R10: An access whose offset is not a multiple of its size sets `misaligned`, which then stays 1 until reset; the access is still carried out.
- R11: Reset clears the pending word, the enable word, all mailbox bytes, `irq` and `misaligned`.
- R12: Every cycle with `acc_valid` = 1 produces `rsp_valid` = 1 in the next cycle, and `rsp_valid` is 0 after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | ADDR_W | Access address; bits [8:0] decoded |
| acc_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| acc_wdata | input | DATA_W | Write data, low bytes used first |
| set_valid | input | 1 | Pending-bit set request |
| set_num | input | SET_W | Bit number to set in the pending word |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | DATA_W | Read data, zero on writes and errors |
| irq | output | 1 | Interrupt line to the core |
| misaligned | output | 1 | Sticky flag for an unaligned access |

## Verification
The hardest states to reach are mailbox accesses that straddle a 64-bit entry or touch the last bytes before the end of the mailbox. An aligned bench never produces them. The stimulus writes a full entry, overwrites one byte in its middle and then reads a 4-byte window that starts two bytes into the entry and mixes old and new bytes. It then reads a 4-byte window ending exactly at the end of the mailbox, and after that an 8-byte window that runs past the end. For the out-of-range write it reads the affected entry back to show that nothing changed. The irq line is also taken through a clear that leaves bits pending and then through a clear that empties the word, so both outcomes of the zero test are seen.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned WIN_BITS = 9;
  localparam logic [WIN_BITS-1:0] OFF_CLEAR  = 9'h000;
  localparam logic [WIN_BITS-1:0] OFF_SET    = 9'h008;
  localparam logic [WIN_BITS-1:0] OFF_STATUS = 9'h010;
  localparam logic [WIN_BITS-1:0] OFF_ENABLE = 9'h018;
  localparam logic [WIN_BITS-1:0] OFF_MB_LO  = 9'h020;
endpackage

// File: rtl/ipi_status.sv
module ipi_status #(
  parameter int W     = 32,
  parameter int SET_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [SET_W-1:0] set_num,
  input  logic             clr_en,
  input  logic [W-1:0]     clr_mask,
  output logic [W-1:0]     status,
  output logic             irq
);
  logic [W-1:0] set_bit;
  logic [W-1:0] kept;
  logic [W-1:0] status_next;

  always_comb begin
    set_bit     = set_en ? (W'(1) << set_num) : '0;
    kept        = clr_en ? (status & ~clr_mask) : status;
    status_next = kept | set_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_next;
      irq    <= |status_next;
    end
  end

  // R2
  set_raises_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> (irq && status[$past(set_num)]));

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en && ((status & ~clr_mask) == '0)) |=> !irq);
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int BYTES = 32,
  parameter int DW    = 64,
  parameter int AW    = $clog2(BYTES),
  parameter int NW    = $clog2(DW/8) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] base,
  input  logic [NW-1:0] nbytes,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);

  logic [7:0]      mem  [BYTES];
  logic [BYTES-1:0] we;
  logic [LW-1:0]   lane [BYTES];
  logic [AW:0]     diff;
  logic [AW:0]     idx;

  always_comb begin
    diff = '0;
    for (int j = 0; j < BYTES; j++) begin
      diff    = (AW+1)'(j) - {1'b0, base};
      we[j]   = wr_en && (diff < (AW+1)'(nbytes));
      lane[j] = diff[LW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < BYTES; j++) mem[j] <= '0;
    end else begin
      for (int j = 0; j < BYTES; j++)
        if (we[j]) mem[j] <= wdata[lane[j]*8 +: 8];
    end
  end

  always_comb begin
    rdata = '0;
    idx   = '0;
    for (int i = 0; i < LANES; i++) begin
      idx = {1'b0, base} + (AW+1)'(i);
      if ((NW'(i) < nbytes) && (idx < (AW+1)'(BYTES)))
        rdata[i*8 +: 8] = mem[idx[AW-1:0]];
    end
  end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int ACT_W    = 32,
  parameter int SET_W    = $clog2(ACT_W),
  parameter int MB_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              set_valid,
  input  logic [SET_W-1:0]  set_num,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq,
  output logic              misaligned
);
  localparam int OW    = WIN_BITS;
  localparam int MB_AW = $clog2(MB_BYTES);
  localparam int SZ_W  = $clog2(DATA_W/8) + 1;
  localparam logic [OW:0] MB_START = (OW+1)'(OFF_MB_LO);
  localparam logic [OW:0] MB_END   = (OW+1)'(OFF_MB_LO) + (OW+1)'(MB_BYTES);

  logic [OW-1:0]     off;
  logic [SZ_W-1:0]   nbytes;
  logic [SZ_W-1:0]   size_mask;
  logic [OW:0]       end_off;
  logic              in_mb, mb_bad, mb_ok;
  logic              hit_clear, hit_set, hit_status, hit_enable;
  logic              err_c, misal_c;
  logic [MB_AW-1:0]  mb_base;
  logic [DATA_W-1:0] mb_rdata;
  logic [DATA_W-1:0] rd_c;
  logic [ACT_W-1:0]  status;
  logic [ACT_W-1:0]  enable_q;

  always_comb begin
    off        = acc_addr[OW-1:0];
    nbytes     = SZ_W'(1) << acc_size;
    size_mask  = nbytes - SZ_W'(1);
    end_off    = {1'b0, off} + (OW+1)'(nbytes);
    in_mb      = ({1'b0, off} >= MB_START) && ({1'b0, off} < MB_END);
    mb_bad     = in_mb && (end_off > MB_END);
    mb_ok      = in_mb && !mb_bad;
    mb_base    = MB_AW'({1'b0, off} - MB_START);
    hit_clear  = (off == OFF_CLEAR);
    hit_set    = (off == OFF_SET);
    hit_status = (off == OFF_STATUS);
    hit_enable = (off == OFF_ENABLE);
    misal_c    = |(off[SZ_W-2:0] & size_mask[SZ_W-2:0]);
    err_c      = mb_bad
               || (!in_mb && !(hit_clear || hit_set || hit_status || hit_enable))
               || (acc_write && (hit_status || hit_set));
    rd_c = '0;
    if (hit_status) rd_c = DATA_W'(status);
    if (hit_enable) rd_c = DATA_W'(enable_q);
    if (mb_ok)      rd_c = mb_rdata;
  end

  ipi_status #(.W(ACT_W), .SET_W(SET_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_en   (set_valid),
    .set_num  (set_num),
    .clr_en   (acc_valid && acc_write && hit_clear),
    .clr_mask (acc_wdata[ACT_W-1:0]),
    .status   (status),
    .irq      (irq)
  );

  ipi_mailbox #(.BYTES(MB_BYTES), .DW(DATA_W), .AW(MB_AW), .NW(SZ_W)) u_mailbox (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (acc_valid && acc_write && mb_ok),
    .base   (mb_base),
    .nbytes (nbytes),
    .wdata  (acc_wdata),
    .rdata  (mb_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q   <= '0;
      misaligned <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (acc_valid && acc_write && hit_enable) enable_q <= acc_wdata[ACT_W-1:0];
      if (acc_valid && misal_c) misaligned <= 1'b1;
      rsp_valid <= acc_valid;
      rsp_err   <= acc_valid && err_c;
      rsp_rdata <= (acc_valid && !acc_write && !err_c) ? rd_c : '0;
    end
  end

  // R4
  guarded_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && (acc_addr[OW-1:0] == OFF_STATUS || acc_addr[OW-1:0] == OFF_SET))
    |=> rsp_err);

  // R8
  mb_window_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && mb_bad) |=> (rsp_err && rsp_rdata == '0));

  // R10
  misalign_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    misaligned |=> misaligned);

  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);
endmodule

// File: tb/ipi_core_regs_bench.sv
module ipi_core_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [63:0] acc_wdata = '0;
  logic        set_valid = 1'b0;
  logic [4:0]  set_num = '0;
  logic        rsp_valid, rsp_err, irq, misaligned;
  logic [63:0] rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic        r_valid, r_err;
  logic [63:0] r_data;

  always #5 clk = ~clk;

  ipi_core_regs u_ipi_core_regs (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .set_valid(set_valid), .set_num(set_num), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq), .misaligned(misaligned)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [15:0] addr, input logic [1:0] sz,
                     input logic [63:0] data);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = addr; acc_size = sz; acc_wdata = data;
    @(posedge clk);
    #1;
    r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic pulse_set(input logic [4:0] n);
    @(negedge clk);
    set_valid = 1'b1; set_num = n;
    @(posedge clk);
    #1;
    set_valid = 1'b0;
  endtask

  task automatic test_reset;
    check("R11 irq", 64'(irq), 64'd0);
    check("R11 misaligned", 64'(misaligned), 64'd0);
    acc(1'b0, 16'h0010, 2'd2, '0);
    check("R12 rsp_valid", 64'(r_valid), 64'd1);
    check("R11 pending", r_data, 64'd0);
    acc(1'b0, 16'h0018, 2'd2, '0);
    check("R11 enable", r_data, 64'd0);
    acc(1'b0, 16'h0038, 2'd3, '0);
    check("R11 mailbox", r_data, 64'd0);
    @(posedge clk); #1;
    check("R12 idle rsp_valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic test_set;
    pulse_set(5'd5);
    check("R2 irq rises", 64'(irq), 64'd1);
    acc(1'b0, 16'h0010, 2'd2, '0);
    check("R2 pending bit5", r_data, 64'h20);
    pulse_set(5'd31);
    check("R2 irq held", 64'(irq), 64'd1);
    acc(1'b0, 16'h0010, 2'd2, '0);
    check("R2 pending bit31", r_data, 64'h8000_0020);
  endtask

  task automatic test_clear;
    acc(1'b1, 16'h0000, 2'd2, 64'h20);
    check("R3 clear err", 64'(r_err), 64'd0);
    check("R3 irq stays", 64'(irq), 64'd1);
    acc(1'b0, 16'h0010, 2'd2, '0);
    check("R3 partial clear", r_data, 64'h8000_0000);
    acc(1'b1, 16'h0000, 2'd2, 64'hFFFF_FFFF);
    check("R3 irq falls", 64'(irq), 64'd0);
    acc(1'b0, 16'h0010, 2'd2, '0);
    check("R3 empty", r_data, 64'd0);
  endtask

  task automatic test_reject;
    pulse_set(5'd3);
    acc(1'b1, 16'h0010, 2'd2, 64'hFFFF);
    check("R4 pending write err", 64'(r_err), 64'd1);
    acc(1'b1, 16'h0008, 2'd2, 64'h1);
    check("R4 set write err", 64'(r_err), 64'd1);
    acc(1'b0, 16'h0010, 2'd2, '0);
    check("R4 pending unchanged", r_data, 64'h8);
    acc(1'b0, 16'h0008, 2'd2, '0);
    check("R4 set read zero", r_data, 64'd0);
    check("R4 set read no err", 64'(r_err), 64'd0);
    acc(1'b0, 16'h0000, 2'd2, '0);
    check("R4 clear read zero", r_data, 64'd0);
    acc(1'b1, 16'h0000, 2'd2, 64'h8);
    check("R4 cleanup irq", 64'(irq), 64'd0);
  endtask

  task automatic test_enable;
    acc(1'b1, 16'h0018, 2'd2, 64'hA5A5_5A5A);
    acc(1'b0, 16'h0018, 2'd2, '0);
    check("R5 enable readback", r_data, 64'hA5A5_5A5A);
    acc(1'b1, 16'h0018, 2'd2, 64'h0);
    pulse_set(5'd0);
    check("R5 enable no gate", 64'(irq), 64'd1);
    acc(1'b1, 16'h0000, 2'd2, 64'h1);
  endtask

  task automatic test_mailbox;
    acc(1'b1, 16'h0020, 2'd3, 64'h1122_3344_5566_7788);
    acc(1'b0, 16'h0021, 2'd0, '0);
    check("R6 byte read", r_data, 64'h77);
    acc(1'b0, 16'h0026, 2'd1, '0);
    check("R6 half read", r_data, 64'h1122);
    acc(1'b0, 16'h0024, 2'd2, '0);
    check("R6 word read", r_data, 64'h1122_3344);
    acc(1'b1, 16'h0023, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    acc(1'b0, 16'h0020, 2'd3, '0);
    check("R7 byte write", r_data, 64'h1122_3344_FF66_7788);
  endtask

  task automatic test_alias;
    acc(1'b1, 16'h0230, 2'd3, 64'h0123_4567_89AB_CDEF);
    acc(1'b0, 16'h0030, 2'd3, '0);
    check("R1 alias mailbox", r_data, 64'h0123_4567_89AB_CDEF);
    acc(1'b0, 16'hFE18, 2'd2, '0);
    check("R1 alias register err", 64'(r_err), 64'd0);
  endtask

  task automatic test_unknown;
    acc(1'b0, 16'h0004, 2'd2, '0);
    check("R9 unknown err", 64'(r_err), 64'd1);
    check("R9 unknown data", r_data, 64'd0);
    acc(1'b1, 16'h00C0, 2'd2, 64'h5);
    check("R9 unknown write err", 64'(r_err), 64'd1);
  endtask

  task automatic test_misalign;
    check("R10 flag clear", 64'(misaligned), 64'd0);
    acc(1'b0, 16'h0022, 2'd2, '0);
    check("R10 data still read", r_data, 64'h3344_FF66);
    check("R10 flag set", 64'(misaligned), 64'd1);
    acc(1'b0, 16'h0020, 2'd0, '0);
    check("R10 flag sticky", 64'(misaligned), 64'd1);
  endtask

  task automatic test_window;
    acc(1'b1, 16'h0038, 2'd3, 64'hCAFE_BABE_DEAD_BEEF);
    acc(1'b0, 16'h003C, 2'd2, '0);
    check("R8 last word ok", r_data, 64'hCAFE_BABE);
    check("R8 last word no err", 64'(r_err), 64'd0);
    acc(1'b0, 16'h003C, 2'd3, '0);
    check("R8 overrun read err", 64'(r_err), 64'd1);
    check("R8 overrun read data", r_data, 64'd0);
    acc(1'b1, 16'h003C, 2'd3, 64'h0);
    check("R8 overrun write err", 64'(r_err), 64'd1);
    acc(1'b0, 16'h0038, 2'd3, '0);
    check("R8 no write", r_data, 64'hCAFE_BABE_DEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    test_reset();
    test_set();
    test_clear();
    test_reject();
    test_enable();
    test_mailbox();
    test_alias();
    test_unknown();
    test_misalign();
    test_window();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule